// File: doc/BRIEF.md
# Thread dispatch queue

This block sits between hardware producers and a processor that runs one software thread per input channel. Each channel feeds words into its own first-in first-out data queue. When a channel accepts a word, its thread number, which is the channel index, is appended to a shared ordering queue. The ordering queue therefore records which thread has work, in the order the work arrived. The ordering queue has exactly one slot per thread, and a thread number that is already waiting is never appended a second time.

Software finds pending work by polling. It reads a valid flag and the thread number at the head of the ordering queue, then strobes a pop to claim that thread. It drains words from that thread's data queue through a channel-selected read port, and strobes done when the thread has finished. Dispatch is non-preemptive: no further head is offered while a thread is running. A pop issued while a thread is still running is a protocol error and is latched in a sticky flag. A word written to a full data queue is discarded and latched in a sticky per-channel overflow flag.

Top module: `thread_dispatch_queue`

## Requirements
- R1: Each channel has its own data queue. Accepted words leave through rd_data_o in the order they were written. rd_valid_o and rd_data_o show the head of the queue selected by rd_ch_i in the same cycle. rd_i removes that head when the queue is not empty.
- R2: A word accepted on channel c at a clock edge makes thread number c (equal to the channel index) available in the ordering queue after that same edge. Thread numbers leave the ordering queue in arrival order.
- R3: When several channels accept words at the same edge, their thread numbers are appended in ascending channel index order, so the lowest index comes first.
- R4: A thread number that is already waiting in the ordering queue is not appended again. A thread whose number is popped at the same edge as a new word on its channel is appended again at the tail.
- R5: head_valid_o is 1 only when the ordering queue is not empty and no thread is running. head_id_o carries the head thread number when head_valid_o is 1, and 0 otherwise.
- R6: pop_i while head_valid_o is 1 removes the head and sets busy_o. busy_o stays at 1 until done_i is seen. done_i while busy_o is 0 has no effect.
- R7: pop_i while busy_o is 1 sets the sticky proto_err_o and leaves the ordering queue unchanged. pop_i with an empty ordering queue and no running thread has no effect.
- R8: A write to a full data queue is dropped, even when that queue is read in the same cycle. The write sets the sticky overflow_o bit of that channel. A dropped word does not append a thread number.
- R9: While rst_ni is low, all queues are empty, and busy_o, proto_err_o and overflow_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | NUM_CH | Per-channel write strobe |
| wr_data_i | input | NUM_CH*DATA_W | Per-channel write words, channel c at bits c*DATA_W upward |
| rd_i | input | 1 | Remove the head word of the selected data queue |
| rd_ch_i | input | ID_W | Data queue selected for reading |
| rd_valid_o | output | 1 | Selected data queue is not empty |
| rd_data_o | output | DATA_W | Head word of the selected data queue |
| head_valid_o | output | 1 | A thread is ready to be dispatched |
| head_id_o | output | ID_W | Thread number at the head of the ordering queue |
| pop_i | input | 1 | Claim the head thread |
| done_i | input | 1 | Running thread has completed |
| busy_o | output | 1 | A dispatched thread is running |
| proto_err_o | output | 1 | Sticky: pop issued while a thread was running |
| overflow_o | output | NUM_CH | Sticky: write dropped on a full data queue |

## Verification
The assertions check several properties on every cycle. The ordering queue's occupancy always equals the number of threads marked waiting, so no thread number is held twice. A pop never reaches an empty ordering queue. A running thread stays running until done. A pop during a running thread raises the error flag. A write to a full data queue leaves its occupancy unchanged and raises the overflow flag. Some behaviour only the bench's scenarios and its cycle-level reference model can show: the exact dispatch order of same-cycle and staggered arrivals, re-queueing a thread popped in the cycle its channel receives new data, word ordering through each data queue, and the exact values on the status outputs.

// File: rtl/tdq_pkg.sv
package tdq_pkg;
  typedef enum logic {
    DISP_IDLE = 1'b0,
    DISP_RUN  = 1'b1
  } disp_state_e;
endpackage

// File: rtl/tdq_data_fifo.sv
module tdq_data_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [CW-1:0]     cnt_q;
  logic              ovf_q;
  logic              push, pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push    = wr_i && !full_o;   // full checked before same-cycle read
  assign pop     = rd_i && !empty_o;
  assign rd_data_o = mem_q[rptr_q];
  assign ovf_o   = ovf_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (push) wptr_q <= ptr_inc(wptr_q);
      if (pop)  rptr_q <= ptr_inc(rptr_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
      if (wr_i && full_o) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wptr_q] <= wr_data_i;
  end

  a_r8_full_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_i && !rd_i) |=> (cnt_q == $past(cnt_q)));
  a_r8_overflow_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o) |=> ovf_o);
  a_r1_read_frees_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !empty_o && !wr_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/tdq_ctrl_queue.sv
module tdq_ctrl_queue #(
  parameter int NUM_CH = 4,
  localparam int ID_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] push_mask_i,
  input  logic              pop_i,
  output logic              nonempty_o,
  output logic [ID_W-1:0]   head_id_o
);
  localparam int CW = $clog2(NUM_CH + 1);

  logic [ID_W-1:0]   q_q [NUM_CH];
  logic [ID_W-1:0]   q_n [NUM_CH];
  logic [NUM_CH-1:0] pend_q, pend_n;
  logic [CW-1:0]     cnt_q, cnt_n;

  assign nonempty_o = (cnt_q != '0);
  assign head_id_o  = q_q[0];

  // pop first (shift), then append new arrivals in ascending index order
  always_comb begin
    q_n    = q_q;
    pend_n = pend_q;
    cnt_n  = cnt_q;
    if (pop_i) begin
      for (int i = 0; i < NUM_CH - 1; i++) q_n[i] = q_q[i+1];
      q_n[NUM_CH-1] = '0;
      cnt_n = cnt_n - CW'(1);
      for (int c = 0; c < NUM_CH; c++)
        if (ID_W'(c) == q_q[0]) pend_n[c] = 1'b0;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (push_mask_i[c] && !pend_n[c] && (cnt_n < CW'(NUM_CH))) begin
        for (int s = 0; s < NUM_CH; s++)
          if (CW'(s) == cnt_n) q_n[s] = ID_W'(c);
        pend_n[c] = 1'b1;
        cnt_n     = cnt_n + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_CH; i++) q_q[i] <= '0;
      pend_q <= '0;
      cnt_q  <= '0;
    end else begin
      q_q    <= q_n;
      pend_q <= pend_n;
      cnt_q  <= cnt_n;
    end
  end

  a_r4_pending_matches_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CW'($countones(pend_q)) == cnt_q));
  a_r7_pop_only_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
  a_r2_pop_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && push_mask_i == '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/tdq_dispatch.sv
module tdq_dispatch
  import tdq_pkg::*;
#(
  parameter int ID_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pop_i,
  input  logic            done_i,
  input  logic            q_nonempty_i,
  input  logic [ID_W-1:0] q_head_i,
  output logic            pop_fire_o,
  output logic            head_valid_o,
  output logic [ID_W-1:0] head_id_o,
  output logic            busy_o,
  output logic            proto_err_o
);
  disp_state_e state_q;
  logic        err_q;

  assign busy_o       = (state_q == DISP_RUN);
  assign head_valid_o = q_nonempty_i && !busy_o;
  assign head_id_o    = head_valid_o ? q_head_i : '0;
  assign pop_fire_o   = pop_i && head_valid_o;
  assign proto_err_o  = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DISP_IDLE;
      err_q   <= 1'b0;
    end else begin
      if (pop_i && busy_o) err_q <= 1'b1;
      unique case (state_q)
        DISP_IDLE: if (pop_fire_o) state_q <= DISP_RUN;
        DISP_RUN:  if (done_i)     state_q <= DISP_IDLE;
        default:                   state_q <= DISP_IDLE;
      endcase
    end
  end

  a_r6_pop_starts_thread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && q_nonempty_i && !busy_o) |=> busy_o);
  a_r6_run_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_i) |=> busy_o);
  a_r7_pop_while_busy_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && busy_o) |=> proto_err_o);
endmodule

// File: rtl/thread_dispatch_queue.sv
module thread_dispatch_queue #(
  parameter int NUM_CH   = 4,
  parameter int DATA_W   = 8,
  parameter int DQ_DEPTH = 4,
  localparam int ID_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH-1:0]        wr_valid_i,
  input  logic [NUM_CH*DATA_W-1:0] wr_data_i,
  input  logic                     rd_i,
  input  logic [ID_W-1:0]          rd_ch_i,
  output logic                     rd_valid_o,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     head_valid_o,
  output logic [ID_W-1:0]          head_id_o,
  input  logic                     pop_i,
  input  logic                     done_i,
  output logic                     busy_o,
  output logic                     proto_err_o,
  output logic [NUM_CH-1:0]        overflow_o
);
  logic [DATA_W-1:0] dout  [NUM_CH];
  logic [NUM_CH-1:0] empty, full, accepted;
  logic              rd_ch_ok;
  logic              q_nonempty, pop_fire;
  logic [ID_W-1:0]   q_head;

  assign rd_ch_ok = (int'(rd_ch_i) < NUM_CH);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tdq_data_fifo #(
      .DATA_W (DATA_W),
      .DEPTH  (DQ_DEPTH)
    ) u_fifo (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_valid_i[c]),
      .wr_data_i (wr_data_i[c*DATA_W +: DATA_W]),
      .rd_i      (rd_i && rd_ch_ok && (rd_ch_i == ID_W'(c))),
      .rd_data_o (dout[c]),
      .empty_o   (empty[c]),
      .full_o    (full[c]),
      .ovf_o     (overflow_o[c])
    );
    assign accepted[c] = wr_valid_i[c] && !full[c];
  end

  assign rd_valid_o = rd_ch_ok && !empty[rd_ch_i];
  assign rd_data_o  = rd_ch_ok ? dout[rd_ch_i] : '0;

  tdq_ctrl_queue #(
    .NUM_CH (NUM_CH)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_mask_i (accepted),
    .pop_i       (pop_fire),
    .nonempty_o  (q_nonempty),
    .head_id_o   (q_head)
  );

  tdq_dispatch #(
    .ID_W (ID_W)
  ) u_disp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pop_i        (pop_i),
    .done_i       (done_i),
    .q_nonempty_i (q_nonempty),
    .q_head_i     (q_head),
    .pop_fire_o   (pop_fire),
    .head_valid_o (head_valid_o),
    .head_id_o    (head_id_o),
    .busy_o       (busy_o),
    .proto_err_o  (proto_err_o)
  );

  a_r5_no_offer_while_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !head_valid_o);
  a_r2_arrival_makes_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|accepted && !pop_i) |=> (head_valid_o || busy_o));
endmodule

// File: tb/tb_thread_dispatch_queue.sv
module tb_thread_dispatch_queue;
  localparam int NCH = 4;
  localparam int DW  = 8;
  localparam int DEP = 4;
  localparam int IW  = 2;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NCH-1:0]  wr_v = '0;
  logic [NCH*DW-1:0] wr_d = '0;
  logic            rd = 1'b0;
  logic [IW-1:0]   rd_ch = '0;
  logic            pop = 1'b0, done = 1'b0;
  logic            rd_valid_o, head_valid_o, busy_o, proto_err_o;
  logic [DW-1:0]   rd_data_o;
  logic [IW-1:0]   head_id_o;
  logic [NCH-1:0]  overflow_o;

  always #4 clk = ~clk;

  thread_dispatch_queue #(.NUM_CH(NCH), .DATA_W(DW), .DQ_DEPTH(DEP)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_v), .wr_data_i(wr_d),
    .rd_i(rd), .rd_ch_i(rd_ch), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .head_valid_o(head_valid_o), .head_id_o(head_id_o), .pop_i(pop), .done_i(done),
    .busy_o(busy_o), .proto_err_o(proto_err_o), .overflow_o(overflow_o));

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  // reference model
  int dq [NCH][$];
  int cq [$];
  bit m_busy, m_perr;
  bit [NCH-1:0] m_ovf;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit in_cq(input int c);
    foreach (cq[i]) if (cq[i] == c) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) dq[c].delete();
    cq.delete();
    m_busy = 0; m_perr = 0; m_ovf = '0;
  endtask

  task automatic model_step();
    bit f [NCH];
    bit fire;
    if (!rst_ni) begin model_reset(); return; end
    for (int c = 0; c < NCH; c++) f[c] = (dq[c].size() == DEP);
    if (rd && dq[rd_ch].size() > 0) void'(dq[rd_ch].pop_front());
    for (int c = 0; c < NCH; c++)
      if (wr_v[c]) begin
        if (f[c]) m_ovf[c] = 1'b1;
        else dq[c].push_back(int'(wr_d[c*DW +: DW]));
      end
    fire = pop && !m_busy && cq.size() > 0;
    if (pop && m_busy) m_perr = 1'b1;
    if (fire) begin void'(cq.pop_front()); m_busy = 1'b1; end
    else if (done) m_busy = 1'b0;
    for (int c = 0; c < NCH; c++)
      if (wr_v[c] && !f[c] && !in_cq(c)) cq.push_back(c);
  endtask

  task automatic compare();
    bit hv;
    hv = !m_busy && cq.size() > 0;
    chk("R5 head_valid", int'(head_valid_o), int'(hv));
    chk("R2/R3/R4 head_id", int'(head_id_o), hv ? cq[0] : 0);
    chk("R6 busy", int'(busy_o), int'(m_busy));
    chk("R7 proto_err", int'(proto_err_o), int'(m_perr));
    chk("R8 overflow", int'(overflow_o), int'(m_ovf));
    chk("R1 rd_valid", int'(rd_valid_o), int'(dq[rd_ch].size() > 0));
    if (dq[rd_ch].size() > 0) chk("R1 rd_data", int'(rd_data_o), dq[rd_ch][0]);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle_inputs();
    wr_v = '0; rd = 0; pop = 0; done = 0;
  endtask

  task automatic put(input int c, input int val);
    wr_v[c] = 1'b1;
    wr_d[c*DW +: DW] = DW'(val);
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_ni = 1'b0;
    tick(); tick();
    // R9: everything cleared during reset
    chk("R9 reset head_valid", int'(head_valid_o), 0);
    chk("R9 reset busy", int'(busy_o), 0);
    chk("R9 reset flags", int'({proto_err_o, overflow_o}), 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    tick();

    // R3: same-cycle arrivals, lowest index first
    for (int c = 0; c < NCH; c++) put(c, 16 + c);
    tick(); idle_inputs();
    chk("R3 first head", int'(head_id_o), 0);
    // R4: repeat write to a waiting thread
    put(2, 40); tick(); idle_inputs();
    chk("R4 no duplicate", int'(head_id_o), 0);
    // R6: dispatch, drain, complete
    pop = 1; tick(); idle_inputs();
    chk("R6 busy after pop", int'(busy_o), 1);
    rd_ch = 0; rd = 1; tick(); idle_inputs(); tick();
    done = 1; tick(); idle_inputs();
    chk("R6 next head", int'(head_id_o), 1);
    // R4: pop head in the same cycle its channel receives data
    pop = 1; put(1, 77); tick(); idle_inputs();
    done = 1; tick(); idle_inputs();
    chk("R4 requeued order", int'(head_id_o), 2);
    // R6: done while idle ignored
    done = 1; tick(); idle_inputs();
    chk("R6 done idle", int'(head_valid_o), 1);

    // random traffic with legal handshake
    for (int i = 0; i < 3000; i++) begin
      idle_inputs();
      for (int c = 0; c < NCH; c++)
        if ($urandom_range(0, 5) == 0) put(c, int'($urandom_range(0, 255)));
      rd_ch = IW'($urandom_range(0, NCH - 1));
      rd    = ($urandom_range(0, 2) != 0);
      if (!m_busy) pop = ($urandom_range(0, 2) == 0);
      else done = ($urandom_range(0, 3) == 0);
      tick();
    end
    idle_inputs();

    // error cases after fresh reset
    do_reset();
    tick();
    // R7: pop with empty queue and idle
    pop = 1; tick(); idle_inputs();
    chk("R7 empty pop ignored", int'(busy_o) + int'(proto_err_o), 0);
    // R2: staggered arrivals keep order
    put(3, 5); tick(); idle_inputs();
    put(1, 6); tick(); idle_inputs();
    chk("R2 staggered head", int'(head_id_o), 3);
    pop = 1; tick(); idle_inputs();
    // R7: second pop without done
    pop = 1; tick(); idle_inputs();
    chk("R7 proto_err set", int'(proto_err_o), 1);
    done = 1; tick(); idle_inputs();
    chk("R7 queue unchanged", int'(head_id_o), 1);
    // R8: overflow channel 2, including same-cycle read
    for (int k = 0; k < DEP; k++) begin put(2, 100 + k); tick(); idle_inputs(); end
    rd_ch = 2; rd = 1; put(2, 200); tick(); idle_inputs();
    chk("R8 overflow bit", int'(overflow_o), 4);
    for (int k = 0; k < DEP; k++) begin rd = 1; tick(); end
    idle_inputs(); tick();
    chk("R8 drained", int'(rd_valid_o), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule